// File: doc/BRIEF.md
# Label-Switched Bufferless Mesh Router

This block is one node of a two-dimensional mesh network-on-chip. It has five ports (north, east, south, west and the local node) and stores no flits. Each packet opens with a header flit whose low bits hold a label. A small writable table maps that label to an output port. The router then keeps the crossbar path from that input to that output open, like a circuit, until the packet's closing flit is accepted downstream. Payload flits follow the held path and are never routed themselves.

The table is loaded through a host write port before traffic starts. A header whose label has no usable entry is dropped, and this raises a sticky error flag. Every flit moves on a valid/ready handshake. An input's ready comes combinationally from the ready of the output it has been granted. When several inputs claim the same free output, a fixed priority picks one and the others see ready low.

Flits are `DATA_W + 2` bits wide. The top two bits hold the flit type and bits `[LABEL_W-1:0]` hold the label in a header. Port codes are 0 north, 1 east, 2 south, 3 west, 4 local.

Top module: `lbr_router`

## Requirements
- R1: After reset, no output is valid, the error flag is low, and every table entry is invalid. A header arriving before any table write is therefore dropped.
- R2: A header (type 2'b01) whose label hits a valid entry appears in the same cycle, unchanged, on the output named by the entry's port code (0 N, 1 E, 2 S, 3 W, 4 local).
- R3: Once a header has been accepted, payload flits (type 2'b00) from that input go to the same output whatever their low bits hold, even if the table entry is rewritten meanwhile.
- R4: The path is released on the cycle its tail flit (type 2'b10) is accepted downstream. The next header from that input is looked up again.
- R5: A header whose label selects an invalid entry is consumed: input ready is high and no output is valid. The error flag then rises on the next cycle and stays high until reset.
- R6: When several free inputs send headers to the same free output in one cycle, the winner is chosen in the fixed order north, east, south, west, local. Losers see ready low.
- R7: An output held by a packet is given to no other header until that packet's tail is accepted. A waiting header sees ready low.
- R8: A single-flit packet (type 2'b11) is routed like a header but reserves no path.
- R9: A granted input's ready equals the ready of its output in the same cycle. A tail that is not accepted does not release the path.
- R10: A payload or tail flit arriving at an input that holds no path is discarded: ready is high and no output is valid.
- R11: Packets from different inputs to different outputs pass in the same cycle.
- R12: An entry marked valid but holding a port code of 5 to 7 is treated as invalid: the header is dropped and the error flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 5 | Per-input flit valid, index = port code |
| in_flit_i | input | 5*FLIT_W | Input flits, port p at [p*FLIT_W +: FLIT_W] |
| in_ready_o | output | 5 | Per-input ready |
| out_valid_o | output | 5 | Per-output flit valid |
| out_flit_o | output | 5*FLIT_W | Output flits, zero when not valid |
| out_ready_i | input | 5 | Per-output ready from downstream |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_label_i | input | LABEL_W | Label whose entry is written |
| tbl_port_i | input | 3 | Output port code to store |
| tbl_ok_i | input | 1 | Valid bit to store |
| err_o | output | 1 | Sticky error: a header was dropped |

## Verification
A wrong hold bit in an input controller shows at once. A path that is not released turns the packet's next header into a stalled flit on the old output. A lost hold makes the first payload flit either vanish as an orphan or leak onto some other output in the very next cycle. Priority faults show in the cycle where two headers collide, as the wrong flit on the shared output and the wrong ready pattern. A table or error-flag fault shows one cycle after the write or drop, on the next header that uses that label.

// File: rtl/lbr_pkg.sv
package lbr_pkg;
  localparam int NPORT  = 5;
  localparam int PORT_W = $clog2(NPORT);

  typedef enum logic [PORT_W-1:0] {
    P_N = 3'd0, P_E = 3'd1, P_S = 3'd2, P_W = 3'd3, P_L = 3'd4
  } port_e;

  // bit0: opens a packet, bit1: closes a packet
  typedef enum logic [1:0] {
    FT_BODY = 2'b00, FT_HEAD = 2'b01, FT_TAIL = 2'b10, FT_SOLO = 2'b11
  } ftype_e;
endpackage

// File: rtl/lbr_table.sv
module lbr_table
  import lbr_pkg::*;
#(
  parameter int LABEL_W = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [LABEL_W-1:0]       wlabel_i,
  input  logic [PORT_W-1:0]        wport_i,
  input  logic                     wok_i,
  input  logic [NPORT*LABEL_W-1:0] rlabel_i,
  output logic [NPORT-1:0]         hit_o,
  output logic [NPORT*PORT_W-1:0]  port_o
);
  localparam int DEPTH = 2 ** LABEL_W;

  logic [PORT_W-1:0] port_q [DEPTH];
  logic [DEPTH-1:0]  ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_q <= '0;
      for (int e = 0; e < DEPTH; e++) port_q[e] <= '0;
    end else if (we_i) begin
      ok_q[wlabel_i]   <= wok_i;
      port_q[wlabel_i] <= wport_i;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    logic [LABEL_W-1:0] lbl;
    assign lbl = rlabel_i[p*LABEL_W +: LABEL_W];
    assign port_o[p*PORT_W +: PORT_W] = port_q[lbl];
    // codes beyond the last port count as a miss
    assign hit_o[p] = ok_q[lbl] && (port_q[lbl] < PORT_W'(NPORT));
  end
endmodule

// File: rtl/lbr_in_ctrl.sv
module lbr_in_ctrl
  import lbr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        ftype_i,
  input  logic              hit_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic              acc_i,
  output logic [NPORT-1:0]  req_o,
  output logic [NPORT-1:0]  hold_o,
  output logic              drop_o,
  output logic              bad_o,
  output logic              lock_o
);
  logic              lock_q;
  logic [PORT_W-1:0] dest_q;
  logic              opens, closes;

  assign opens  = ftype_i[0];
  assign closes = ftype_i[1];

  always_comb begin
    req_o  = '0;
    hold_o = '0;
    drop_o = 1'b0;
    bad_o  = 1'b0;
    if (lock_q) begin
      for (int k = 0; k < NPORT; k++) begin
        hold_o[k] = (dest_q == PORT_W'(k));
        req_o[k]  = valid_i && (dest_q == PORT_W'(k));
      end
    end else if (valid_i && opens) begin
      if (hit_i) begin
        for (int k = 0; k < NPORT; k++) req_o[k] = (port_i == PORT_W'(k));
      end else begin
        drop_o = 1'b1;
        bad_o  = 1'b1;
      end
    end else if (valid_i) begin
      drop_o = 1'b1;  // orphan body or tail
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      dest_q <= '0;
    end else if (lock_q) begin
      if (acc_i && closes) lock_q <= 1'b0;
    end else if (acc_i && ftype_i == FT_HEAD) begin
      lock_q <= 1'b1;
      dest_q <= port_i;
    end
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/lbr_out_arb.sv
module lbr_out_arb
  import lbr_pkg::*;
(
  input  logic [NPORT-1:0] req_i,
  input  logic [NPORT-1:0] hold_i,
  output logic [NPORT-1:0] gnt_o
);
  always_comb begin
    gnt_o = '0;
    if (|hold_i) begin
      gnt_o = hold_i & req_i;
    end else begin
      for (int k = NPORT - 1; k >= 0; k--) begin
        if (req_i[k]) begin
          gnt_o    = '0;
          gnt_o[k] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lbr_router.sv
module lbr_router
  import lbr_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int LABEL_W = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NPORT-1:0]              in_valid_i,
  input  logic [NPORT*(DATA_W+2)-1:0]   in_flit_i,
  output logic [NPORT-1:0]              in_ready_o,
  output logic [NPORT-1:0]              out_valid_o,
  output logic [NPORT*(DATA_W+2)-1:0]   out_flit_o,
  input  logic [NPORT-1:0]              out_ready_i,
  input  logic                          tbl_we_i,
  input  logic [LABEL_W-1:0]            tbl_label_i,
  input  logic [PORT_W-1:0]             tbl_port_i,
  input  logic                          tbl_ok_i,
  output logic                          err_o
);
  localparam int FLIT_W = DATA_W + 2;

  logic [NPORT*LABEL_W-1:0]      lbl_vec;
  logic [NPORT-1:0]              hit_vec;
  logic [NPORT*PORT_W-1:0]       port_vec;
  logic [NPORT-1:0][NPORT-1:0]   req_io, hold_io, req_oi, hold_oi, gnt_oi;
  logic [NPORT-1:0]              drop_vec, bad_vec, lock_vec, acc_vec;
  logic                          err_q;

  for (genvar p = 0; p < NPORT; p++) begin : g_lbl
    assign lbl_vec[p*LABEL_W +: LABEL_W] = in_flit_i[p*FLIT_W +: LABEL_W];
  end

  lbr_table #(.LABEL_W(LABEL_W)) table_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (tbl_we_i),
    .wlabel_i (tbl_label_i),
    .wport_i  (tbl_port_i),
    .wok_i    (tbl_ok_i),
    .rlabel_i (lbl_vec),
    .hit_o    (hit_vec),
    .port_o   (port_vec)
  );

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    lbr_in_ctrl in_ctrl_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (in_valid_i[i]),
      .ftype_i (in_flit_i[i*FLIT_W+FLIT_W-1 -: 2]),
      .hit_i   (hit_vec[i]),
      .port_i  (port_vec[i*PORT_W +: PORT_W]),
      .acc_i   (acc_vec[i]),
      .req_o   (req_io[i]),
      .hold_o  (hold_io[i]),
      .drop_o  (drop_vec[i]),
      .bad_o   (bad_vec[i]),
      .lock_o  (lock_vec[i])
    );
  end

  always_comb begin
    for (int o = 0; o < NPORT; o++) begin
      for (int i = 0; i < NPORT; i++) begin
        req_oi[o][i]  = req_io[i][o];
        hold_oi[o][i] = hold_io[i][o];
      end
    end
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    lbr_out_arb arb_i (
      .req_i  (req_oi[o]),
      .hold_i (hold_oi[o]),
      .gnt_o  (gnt_oi[o])
    );
  end

  // crossbar and ready return path
  always_comb begin
    out_flit_o = '0;
    for (int o = 0; o < NPORT; o++) begin
      out_valid_o[o] = |gnt_oi[o];
      for (int i = 0; i < NPORT; i++) begin
        if (gnt_oi[o][i]) out_flit_o[o*FLIT_W +: FLIT_W] |= in_flit_i[i*FLIT_W +: FLIT_W];
      end
    end
    for (int i = 0; i < NPORT; i++) begin
      acc_vec[i] = 1'b0;
      for (int o = 0; o < NPORT; o++) acc_vec[i] |= gnt_oi[o][i] & out_ready_i[o];
      in_ready_o[i] = drop_vec[i] | acc_vec[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_q <= 1'b0;
    else if (|bad_vec)  err_q <= 1'b1;
  end

  assign err_o = err_q;
endmodule

// File: rtl/lbr_router_chk.sv
module lbr_router_chk
  import lbr_pkg::*;
#(
  parameter int FLIT_W = 18
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NPORT-1:0]          in_valid_i,
  input logic [NPORT*FLIT_W-1:0]   in_flit_i,
  input logic [NPORT-1:0]          in_ready_o,
  input logic [NPORT-1:0]          out_valid_o,
  input logic                      err_o,
  input logic [NPORT-1:0]          lock_i
);
  for (genvar i = 0; i < NPORT; i++) begin : g_chk
    logic [1:0] ft;
    assign ft = in_flit_i[i*FLIT_W+FLIT_W-1 -: 2];

    AST_LOCK_ON_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(lock_i[i]) |-> $past(in_valid_i[i] && in_ready_o[i] && ft == 2'b01)); // R7

    AST_UNLOCK_ON_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(lock_i[i]) |-> $past(in_valid_i[i] && in_ready_o[i] && ft[1])); // R4
  end

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R5

  AST_ERR_NEEDS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(|in_valid_i)); // R5

  AST_NO_OUT_WITHOUT_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(out_valid_o) <= $countones(in_valid_i)); // R2
endmodule

bind lbr_router lbr_router_chk #(.FLIT_W(FLIT_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_flit_i   (in_flit_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .err_o       (err_o),
  .lock_i      (lock_vec)
);

// File: tb/lbr_router_tb_top.sv
module lbr_router_tb_top;
  localparam int DW = 16;
  localparam int LW = 4;
  localparam int FW = DW + 2;
  localparam int NP = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [NP-1:0]    iv, irdy, ov, ordy;
  logic [FW-1:0]    fl [NP];
  logic [NP*FW-1:0] iflat, oflat;
  logic             we, tok, err;
  logic [LW-1:0]    tlbl;
  logic [2:0]       tport;
  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always_comb for (int p = 0; p < NP; p++) iflat[p*FW +: FW] = fl[p];

  lbr_router #(.DATA_W(DW), .LABEL_W(LW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(iv), .in_flit_i(iflat), .in_ready_o(irdy),
    .out_valid_o(ov), .out_flit_o(oflat), .out_ready_i(ordy),
    .tbl_we_i(we), .tbl_label_i(tlbl), .tbl_port_i(tport), .tbl_ok_i(tok),
    .err_o(err)
  );

  function automatic logic [FW-1:0] mk(input logic [1:0] t, input logic [DW-1:0] d);
    return {t, d};
  endfunction

  function automatic logic [FW-1:0] outp(input int o);
    return oflat[o*FW +: FW];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    iv = '0; ordy = '1; we = 0;
    for (int p = 0; p < NP; p++) fl[p] = '0;
  endtask

  task automatic tbl_wr(input logic [LW-1:0] l, input logic [2:0] p, input logic ok);
    we = 1; tlbl = l; tport = p; tok = ok;
    @(negedge clk);
    we = 0;
  endtask

  task automatic do_reset();
    idle();
    rst_ni = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
  endtask

  task automatic t_load();
    tbl_wr(4'd1, 3'd1, 1);
    tbl_wr(4'd2, 3'd2, 1);
    tbl_wr(4'd3, 3'd4, 1);
    tbl_wr(4'd4, 3'd6, 1);
    tbl_wr(4'd5, 3'd0, 1);
  endtask

  // R2 R3 R9 R4 R8 R10 on the west input
  task automatic t_route();
    fl[3] = mk(2'b01, 16'hA501); iv = 5'b01000;
    #2;
    chk("R2 out valid", 32'(ov), 32'h02);
    chk("R2 east flit", 32'(outp(1)), 32'(fl[3]));
    chk("R2 ready", 32'(irdy[3]), 1);
    @(negedge clk);
    fl[3] = mk(2'b00, 16'h0002);
    we = 1; tlbl = 4'd1; tport = 3'd2; tok = 1;  // retarget label 1 mid-packet
    #2;
    chk("R3 body follows path", 32'(ov), 32'h02);
    chk("R3 body flit", 32'(outp(1)), 32'(fl[3]));
    @(negedge clk);
    we = 0;
    fl[3] = mk(2'b00, 16'h0001);
    #2;
    chk("R3 body after table rewrite", 32'(ov), 32'h02);
    @(negedge clk);
    fl[3] = mk(2'b10, 16'hBEEF); ordy[1] = 0;
    #2;
    chk("R9 ready follows stalled output", 32'(irdy[3]), 0);
    chk("R9 tail offered", 32'(ov), 32'h02);
    @(negedge clk);
    ordy[1] = 1;
    #2;
    chk("R9 tail still on path", 32'(ov), 32'h02);
    chk("R9 ready follows output", 32'(irdy[3]), 1);
    @(negedge clk);
    fl[3] = mk(2'b11, 16'h0C01);
    #2;
    chk("R4 new lookup after release", 32'(ov), 32'h04);
    chk("R8 solo flit", 32'(outp(2)), 32'(fl[3]));
    @(negedge clk);
    fl[3] = mk(2'b00, 16'h0001);
    #2;
    chk("R10 orphan no output", 32'(ov), 0);
    chk("R10 orphan consumed", 32'(irdy[3]), 1);
    @(negedge clk);
    idle();
  endtask

  // R6 R7 on the local output
  task automatic t_prio();
    fl[0] = mk(2'b01, 16'h1003);
    fl[1] = mk(2'b01, 16'h2003);
    fl[4] = mk(2'b01, 16'h3003);
    iv = 5'b10011;
    #2;
    chk("R6 one winner", 32'(ov), 32'h10);
    chk("R6 north wins", 32'(outp(4)), 32'(fl[0]));
    chk("R6 ready pattern", 32'(irdy), 32'h01);
    @(negedge clk);
    fl[0] = mk(2'b00, 16'h1111);
    #2;
    chk("R7 held path body", 32'(outp(4)), 32'(fl[0]));
    chk("R7 waiters stalled", 32'(irdy), 32'h01);
    @(negedge clk);
    fl[0] = mk(2'b10, 16'h1222);
    #2;
    chk("R7 tail passes", 32'(irdy), 32'h01);
    @(negedge clk);
    iv = 5'b10010;
    #2;
    chk("R6 east before local", 32'(outp(4)), 32'(fl[1]));
    chk("R6 ready east", 32'(irdy), 32'h02);
    @(negedge clk);
    fl[1] = mk(2'b10, 16'h2222);
    #2;
    chk("R7 local waits for east tail", 32'(irdy), 32'h02);
    @(negedge clk);
    iv = 5'b10000;
    #2;
    chk("R7 local granted after release", 32'(outp(4)), 32'(fl[4]));
    @(negedge clk);
    fl[4] = mk(2'b10, 16'h3333);
    #2;
    chk("R4 local tail", 32'(irdy), 32'h10);
    @(negedge clk);
    idle();
  endtask

  task automatic t_parallel();
    fl[0] = mk(2'b11, 16'h4002);
    fl[2] = mk(2'b11, 16'h5005);
    iv = 5'b00101;
    #2;
    chk("R11 both outputs", 32'(ov), 32'h05);
    chk("R11 south gets north", 32'(outp(2)), 32'(fl[0]));
    chk("R11 north gets south", 32'(outp(0)), 32'(fl[2]));
    chk("R11 both ready", 32'(irdy), 32'h05);
    @(negedge clk);
    idle();
  endtask

  task automatic t_drop();
    #2;
    chk("R5 err clear before drop", 32'(err), 0);
    fl[4] = mk(2'b01, 16'h0007); iv = 5'b10000;
    #2;
    chk("R5 dropped header consumed", 32'(irdy), 32'h10);
    chk("R5 no output", 32'(ov), 0);
    @(negedge clk);
    idle();
    #2;
    chk("R5 err raised", 32'(err), 1);
    fl[2] = mk(2'b01, 16'h0004); iv = 5'b00100;
    #2;
    chk("R12 bad code dropped", 32'(ov), 0);
    chk("R12 bad code consumed", 32'(irdy[2]), 1);
    @(negedge clk);
    idle();
    repeat (2) @(negedge clk);
    chk("R5 err sticky", 32'(err), 1);
  endtask

  task automatic t_reset_table();
    do_reset();
    #2;
    chk("R1 err cleared", 32'(err), 0);
    fl[3] = mk(2'b01, 16'h0005); iv = 5'b01000;
    #2;
    chk("R1 table empty no output", 32'(ov), 0);
    chk("R1 header consumed", 32'(irdy[3]), 1);
    @(negedge clk);
    idle();
    #2;
    chk("R1 drop flagged", 32'(err), 1);
  endtask

  initial begin
    idle();
    tlbl = '0; tport = '0; tok = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    #2;
    chk("R1 outputs idle", 32'(ov), 0);
    chk("R1 err low", 32'(err), 0);
    @(negedge clk);
    t_load();
    t_route();
    t_prio();
    t_parallel();
    t_drop();
    t_reset_table();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule